// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns one data-movement instruction of a 16-bit, word-addressed machine into an effective address and the memory accesses that go with it. The caller presents the instruction word, the program counter (already advanced past the instruction), the value of the base register and the value of the register to be stored. The unit then forms the address either from the PC plus a signed 9-bit offset or from the base plus a signed 6-bit offset, and drives a single-port synchronous memory through a read strobe, a write strobe and a ready handshake.

Indirect loads and stores take two memory steps: the first read fetches a pointer, and the second access uses that pointer as the final address. The load-effective-address instruction does no memory access. It returns the computed address itself. Loads and address loads end with one register-file write strobe carrying the result and the destination index. Stores end without one. Every instruction ends with a one-cycle completion pulse. The unit takes a new request only while it is idle.

Top module: `ldst_agu`

## Requirements
- R1: PC-relative instructions (opcode field instr[15:12] = 4'b0010 load, 4'b0011 store) access address pc_inc + sign-extended instr[8:0], modulo 2^16. This covers offsets from -256 to +255.
- R2: Base+offset instructions (4'b0110 load, 4'b0111 store) access address base_val + sign-extended instr[5:0], modulo 2^16.
- R3: Indirect instructions (4'b1010 load, 4'b1011 store) first read the pointer at the PC-relative address of R1. They then load from, or store to, the address equal to that pointer, so a load makes two reads and a store makes one read and one write.
- R4: The address-load instruction (4'b1110) writes pc_inc + sign-extended instr[8:0] to the destination register and raises no memory strobe.
- R5: A load or address load completes with exactly one rf_we pulse. That pulse carries rf_waddr = instr[11:9] and rf_wdata equal to the loaded word or the address. A store raises no rf_we and writes src_val to memory exactly once.
- R6: While a strobe is high and mem_ready is low, the strobe stays high and mem_addr stays unchanged. No step advances until mem_ready is seen.
- R7: done is a one-cycle pulse per accepted request. req_ready is high only when the unit is idle. A req_valid seen while the unit is busy is ignored and produces no extra completion.
- R8: Any other opcode completes with done and raises neither rf_we nor any memory strobe.
- R9: mem_rd and mem_wr are never high together, and neither is high while the unit is idle.
- R10: After reset, req_ready is 1 and done, rf_we, mem_rd and mem_wr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only when req_ready is high |
| req_ready | output | 1 | Unit idle and able to accept a request |
| instr | input | 16 | Instruction word |
| pc_inc | input | 16 | PC already incremented past the instruction |
| base_val | input | 16 | Value of the base register named by instr[8:6] |
| src_val | input | 16 | Value of the register named by instr[11:9], used as store data |
| mem_addr | output | 16 | Memory word address |
| mem_rd | output | 1 | Read strobe, held until mem_ready |
| mem_wr | output | 1 | Write strobe, held until mem_ready |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Read data, valid in the cycle mem_ready is high |
| mem_ready | input | 1 | Access completes at the clock edge where this is high |
| done | output | 1 | One-cycle completion pulse |
| rf_we | output | 1 | Destination register write strobe |
| rf_waddr | output | 3 | Destination register index |
| rf_wdata | output | 16 | Value written to the destination register |

## Verification
The hardest case to reach is a request that arrives while an indirect access is stalled between its two memory steps. The pointer is then latched but the final address has not been used. The bench sets its memory model to a three-cycle ready delay, issues an indirect load, and drives req_valid with a different instruction during the stall. It then checks that req_ready stays low, that only one completion appears with the indirect result, and that no further done follows. The wrap-around corner is reached by placing the PC and the base near zero with the most negative offsets.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 3;
  localparam int OFF9_W = 9;
  localparam int OFF6_W = 6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_ACC,
    S_IND,
    S_DONE
  } agu_state_t;

  // PC-relative: sign-extend the 9-bit field and add to the advanced PC
  function automatic logic [WORD_W-1:0] pc_rel(input logic [WORD_W-1:0] pc,
                                               input logic [OFF9_W-1:0] off);
    logic [WORD_W-1:0] ext;
    ext = {{(WORD_W-OFF9_W){off[OFF9_W-1]}}, off};
    return pc + ext;
  endfunction

  // Base+offset: sign-extend the 6-bit field and add to the base register
  function automatic logic [WORD_W-1:0] base_rel(input logic [WORD_W-1:0] base,
                                                 input logic [OFF6_W-1:0] off);
    logic [WORD_W-1:0] ext;
    ext = {{(WORD_W-OFF6_W){off[OFF6_W-1]}}, off};
    return base + ext;
  endfunction
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [3:0]       op,
  input  logic [REG_W-1:0] reg_fld,
  output logic             is_load,
  output logic             is_store,
  output logic             is_ind,
  output logic             is_lea,
  output logic             use_base,
  output logic [REG_W-1:0] dst
);
  always_comb begin
    is_load  = 1'b0;
    is_store = 1'b0;
    is_ind   = 1'b0;
    is_lea   = 1'b0;
    use_base = 1'b0;
    unique case (op)
      4'b0010: is_load  = 1'b1;
      4'b0011: is_store = 1'b1;
      4'b0110: begin is_load  = 1'b1; use_base = 1'b1; end
      4'b0111: begin is_store = 1'b1; use_base = 1'b1; end
      4'b1010: begin is_load  = 1'b1; is_ind   = 1'b1; end
      4'b1011: begin is_store = 1'b1; is_ind   = 1'b1; end
      4'b1110: is_lea = 1'b1;
      default: ;
    endcase
  end

  assign dst = reg_fld;
endmodule

// File: rtl/ldst_addr.sv
module ldst_addr
  import ldst_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0]      pc,
  input  logic [W-1:0]      base,
  input  logic [OFF9_W-1:0] off9,
  input  logic              use_base,
  output logic [W-1:0]      ea
);
  logic [W-1:0] ea_pc;
  logic [W-1:0] ea_base;

  assign ea_pc   = pc_rel(pc, off9);
  assign ea_base = base_rel(base, off9[OFF6_W-1:0]);
  assign ea      = use_base ? ea_base : ea_pc;
endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] pc_inc,
  input  logic [W-1:0] base_val,
  input  logic [W-1:0] src_val,
  output logic [W-1:0] instr_q,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] base_q,
  input  logic         is_load,
  input  logic         is_store,
  input  logic         is_ind,
  input  logic         is_lea,
  input  logic [W-1:0] ea,
  output logic [W-1:0] mem_addr,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ready,
  output logic         done,
  output logic         rf_we,
  output logic [W-1:0] rf_wdata
);
  agu_state_t   state;
  logic [W-1:0] src_q;
  logic [W-1:0] ptr_q;
  logic [W-1:0] res_q;
  logic         wb_q;

  // named events for the assertions
  logic accept;
  logic strobe;
  logic acc_fire;
  logic ptr_fire;
  logic lea_eval;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign strobe    = mem_rd || mem_wr;
  assign acc_fire  = strobe && mem_ready;
  assign ptr_fire  = acc_fire && (state == S_ACC) && is_ind;
  assign lea_eval  = (state == S_EVAL) && is_lea;

  always_comb begin
    mem_rd = 1'b0;
    mem_wr = 1'b0;
    if (state == S_ACC) begin
      mem_rd = is_load || is_ind;
      mem_wr = is_store && !is_ind;
    end else if (state == S_IND) begin
      mem_rd = is_load;
      mem_wr = is_store;
    end
  end

  assign mem_addr  = (state == S_IND) ? ptr_q : ea;
  assign mem_wdata = src_q;
  assign done      = (state == S_DONE);
  assign rf_we     = done && wb_q;
  assign rf_wdata  = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      instr_q <= '0;
      pc_q    <= '0;
      base_q  <= '0;
      src_q   <= '0;
      ptr_q   <= '0;
      res_q   <= '0;
      wb_q    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            instr_q <= instr;
            pc_q    <= pc_inc;
            base_q  <= base_val;
            src_q   <= src_val;
            wb_q    <= 1'b0;
            state   <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (is_lea) begin
            res_q <= ea;
            wb_q  <= 1'b1;
            state <= S_DONE;
          end else if (is_load || is_store) begin
            state <= S_ACC;
          end else begin
            wb_q  <= 1'b0;
            state <= S_DONE;
          end
        end
        S_ACC: begin
          if (acc_fire) begin
            if (is_ind) begin
              ptr_q <= mem_rdata;
              state <= S_IND;
            end else begin
              res_q <= mem_rdata;
              wb_q  <= is_load;
              state <= S_DONE;
            end
          end
        end
        S_IND: begin
          if (acc_fire) begin
            res_q <= mem_rdata;
            wb_q  <= is_load;
            state <= S_DONE;
          end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !strobe); // R9
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !mem_ready) |=> (strobe && $stable(mem_addr))); // R6
  AST_PTR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_fire |=> (mem_addr == $past(mem_rdata))); // R3
  AST_LEA_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    lea_eval |=> (done && rf_we && !strobe)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_WE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done); // R5
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import ldst_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [W-1:0]     instr,
  input  logic [W-1:0]     pc_inc,
  input  logic [W-1:0]     base_val,
  input  logic [W-1:0]     src_val,
  output logic [W-1:0]     mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [W-1:0]     mem_wdata,
  input  logic [W-1:0]     mem_rdata,
  input  logic             mem_ready,
  output logic             done,
  output logic             rf_we,
  output logic [REG_W-1:0] rf_waddr,
  output logic [W-1:0]     rf_wdata
);
  logic [W-1:0] instr_q;
  logic [W-1:0] pc_q;
  logic [W-1:0] base_q;
  logic [W-1:0] ea;
  logic         is_load;
  logic         is_store;
  logic         is_ind;
  logic         is_lea;
  logic         use_base;

  ldst_decode u_dec (
    .op       (instr_q[15:12]),
    .reg_fld  (instr_q[11:9]),
    .is_load  (is_load),
    .is_store (is_store),
    .is_ind   (is_ind),
    .is_lea   (is_lea),
    .use_base (use_base),
    .dst      (rf_waddr)
  );

  ldst_addr #(.W(W)) u_addr (
    .pc       (pc_q),
    .base     (base_q),
    .off9     (instr_q[OFF9_W-1:0]),
    .use_base (use_base),
    .ea       (ea)
  );

  ldst_seq #(.W(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .instr     (instr),
    .pc_inc    (pc_inc),
    .base_val  (base_val),
    .src_val   (src_val),
    .instr_q   (instr_q),
    .pc_q      (pc_q),
    .base_q    (base_q),
    .is_load   (is_load),
    .is_store  (is_store),
    .is_ind    (is_ind),
    .is_lea    (is_lea),
    .ea        (ea),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .done      (done),
    .rf_we     (rf_we),
    .rf_wdata  (rf_wdata)
  );
endmodule

// File: tb/sim_ldst_agu.sv
`timescale 1ns/1ps
module sim_ldst_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] instr = '0, pc_inc = '0, base_val = '0, src_val = '0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, mem_ready;
  logic        done, rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;

  always #2.5 clk = ~clk;

  ldst_agu u0 (.*);

  // memory model
  logic [15:0] mem [int];
  int lat = 0;
  int wcnt = 0;
  int rd_n = 0, wr_n = 0;
  logic [15:0] last_wa = '0, last_wd = '0;
  bit overlap = 0;

  function automatic logic [15:0] peek(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a ^ 16'h5A5A;
  endfunction

  assign mem_ready = (mem_rd || mem_wr) && (wcnt >= lat);
  always @* mem_rdata = mem_rd ? peek(mem_addr) : 16'h0000;

  always @(posedge clk) begin
    if ((mem_rd || mem_wr) && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_wr && mem_ready) begin
      mem[int'(mem_addr)] = mem_wdata;
      last_wa <= mem_addr;
      last_wd <= mem_wdata;
      wr_n <= wr_n + 1;
    end
    if (mem_rd && mem_ready) rd_n <= rd_n + 1;
  end

  // scoreboard
  typedef struct {
    string       rq;
    bit          we;
    logic [2:0]  waddr;
    logic [15:0] wdata;
    int          nrd;
    int          nwr;
    logic [15:0] wa;
    logic [15:0] wd;
    int          rd_base;
    int          wr_base;
  } item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  int issued = 0, retired = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && mem_rd && mem_wr) overlap = 1;
    if (rst_n && req_ready && (mem_rd || mem_wr)) overlap = 1;
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(0, "R7", "unexpected done", 16'd1, 16'd0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(rf_we == it.we, "R5", "rf_we", 16'(rf_we), 16'(it.we));
        if (it.we) begin
          chk(rf_waddr == it.waddr, "R5", "rf_waddr", 16'(rf_waddr), 16'(it.waddr));
          chk(rf_wdata == it.wdata, it.rq, "rf_wdata", rf_wdata, it.wdata);
        end
        chk((rd_n - it.rd_base) == it.nrd, it.rq, "read count",
            16'(rd_n - it.rd_base), 16'(it.nrd));
        chk((wr_n - it.wr_base) == it.nwr, it.rq, "write count",
            16'(wr_n - it.wr_base), 16'(it.nwr));
        if (it.nwr == 1) begin
          chk(last_wa == it.wa, it.rq, "store address", last_wa, it.wa);
          chk(last_wd == it.wd, "R5", "store data", last_wd, it.wd);
        end
      end
      retired++;
    end
  end

  // driver: computes the expectation from the requirements and issues
  task automatic issue(input logic [15:0] ins, input logic [15:0] pc,
                       input logic [15:0] bs, input logic [15:0] sv,
                       input int l, input string rq, input bit poke);
    item_t it;
    logic [15:0] pcrel, brel, ptr;
    pcrel = pc + {{7{ins[8]}}, ins[8:0]};
    brel  = bs + {{10{ins[5]}}, ins[5:0]};
    ptr   = peek(pcrel);
    it = '{rq: rq, we: 0, waddr: ins[11:9], wdata: 0, nrd: 0, nwr: 0,
           wa: 0, wd: sv, rd_base: rd_n, wr_base: wr_n};
    case (ins[15:12])
      4'b0010: begin it.we = 1; it.nrd = 1; it.wdata = peek(pcrel); end
      4'b0011: begin it.nwr = 1; it.wa = pcrel; end
      4'b0110: begin it.we = 1; it.nrd = 1; it.wdata = peek(brel); end
      4'b0111: begin it.nwr = 1; it.wa = brel; end
      4'b1010: begin it.we = 1; it.nrd = 2; it.wdata = peek(ptr); end
      4'b1011: begin it.nrd = 1; it.nwr = 1; it.wa = ptr; end
      4'b1110: begin it.we = 1; it.wdata = pcrel; end
      default: ;
    endcase
    @(negedge clk);
    lat = l;
    instr = ins; pc_inc = pc; base_val = bs; src_val = sv;
    req_valid = 1;
    q.push_back(it);
    issued++;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      // R7: requests while busy must be dropped
      instr = 16'hE3_05; pc_inc = 16'h1234;
      req_valid = 1;
      @(negedge clk);
      chk(req_ready == 0, "R7", "req_ready while busy", 16'(req_ready), 16'd0);
      @(negedge clk);
      chk(req_ready == 0, "R7", "req_ready while busy", 16'(req_ready), 16'd0);
      req_valid = 0;
    end
    while (retired != issued) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(req_ready == 1, "R10", "req_ready", 16'(req_ready), 16'd1);
    chk(done == 0 && rf_we == 0, "R10", "done/rf_we", 16'({done, rf_we}), 16'd0);
    chk(!mem_rd && !mem_wr, "R10", "strobes", 16'({mem_rd, mem_wr}), 16'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // worked sequence: R4 address load, R1 store, R2 store, R3 indirect load
    issue({4'b1110, 3'd1, 9'h1FD}, 16'h30F7, 16'h0, 16'h0, 0, "R4", 0);
    issue({4'b0011, 3'd2, 9'h1FB}, 16'h30F9, 16'h0, 16'h3102, 1, "R1", 0);
    issue({4'b0111, 3'd2, 3'd1, 6'd14}, 16'h30FC, 16'h30F4, 16'h0005, 0, "R2", 0);
    issue({4'b1010, 3'd3, 9'h1F7}, 16'h30FD, 16'h0, 16'h0, 2, "R3", 0);

    // R1 offset extremes and wrap
    issue({4'b0010, 3'd4, 9'h100}, 16'h0010, 16'h0, 16'h0, 0, "R1", 0);
    issue({4'b0010, 3'd5, 9'h0FF}, 16'hFFF0, 16'h0, 16'h0, 1, "R1", 0);
    // R2 negative offset with wrap
    issue({4'b0110, 3'd6, 3'd2, 6'h20}, 16'h0000, 16'h0005, 16'h0, 0, "R2", 0);
    // R3 indirect store
    mem[int'(16'h4000)] = 16'h7ABC;
    issue({4'b1011, 3'd7, 9'h0FF}, 16'h3F01, 16'h0, 16'hBEEF, 1, "R3", 0);
    issue({4'b0010, 3'd0, 9'h000}, 16'h7ABC, 16'h0, 16'h0, 0, "R3", 0);
    // R6 long stall on indirect load with R7 busy requests
    issue({4'b1010, 3'd2, 9'h1F7}, 16'h30FD, 16'h0, 16'h0, 3, "R6", 1);
    repeat (4) @(negedge clk);
    chk(retired == issued, "R7", "no extra done", 16'(retired), 16'(issued));
    // R8 other opcodes
    issue(16'h1234, 16'h0100, 16'h0, 16'h0, 0, "R8", 0);
    issue(16'hC1C0, 16'h0100, 16'h0, 16'h0, 0, "R8", 0);
    // R4 with stall setting: still no access
    issue({4'b1110, 3'd5, 9'h100}, 16'h0080, 16'h0, 16'h0, 3, "R4", 0);
    // R9 strobe exclusivity over the whole run
    chk(!overlap, "R9", "strobe overlap or idle strobe", 16'(overlap), 16'd0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule